// File: doc/BRIEF.md
# Two-Level Interrupt Context Shift Stack

This block keeps a processor's context word (flag bits, bank selects and similar state) across interrupt entry and exit. When an interrupt is taken, the surrounding logic strobes a save. The word is placed in the top slot, and whatever was in the top slot moves down one place. When the handler returns, a restore strobe hands back the top slot's word. The top slot is then refilled from the slot beneath it. The bottom slot keeps its contents on a restore.

The stack never stalls and never refuses a save. When saves nest deeper than the number of slots, the oldest word falls off the bottom, and a one-cycle overflow pulse reports the loss. Software that nests further must keep its own copies. A restore with nothing saved returns the current top word and leaves the slots untouched. It raises a one-cycle underflow pulse. A live count of valid levels is also provided.

The slot count and word width are parameters, and the default is two slots. A parameter also selects whether the slots clear to zero at reset or are left without a reset.

Top module: `ctx_shift_stack`

## Requirements
- R1: With reset clearing enabled (the default), after reset the top and bottom slots, the restored word, the level count and both flags all read zero.
- R2: A save strobe (`push_i` high) loads `ctx_i` into the top slot at the next clock edge. The previous top word moves into the bottom slot, and the level count rises by one.
- R3: A save while the count already equals the slot count discards the previous bottom word. The count stays at its maximum, and `ovf_o` is high for exactly the following cycle.
- R4: A restore strobe (`pop_i` high, `push_i` low) with a nonzero count does four things one edge later. `restore_o` takes the pre-edge top word, the top slot takes the pre-edge bottom word, the bottom slot keeps its value, and the count falls by one.
- R5: Saves of A, B and C followed by two restores leave top/bottom at A/0, then B/A, then C/B, then B/B, then B/B. The two restores return C and then B.
- R6: A restore with a count of zero loads `restore_o` with the current top word and leaves both slots and the count unchanged. `unf_o` is high for exactly the following cycle.
- R7: When `push_i` and `pop_i` are both high, only the save takes effect. `restore_o` keeps its value and no underflow is flagged.
- R8: `ovf_o` and `unf_o` are low in every cycle that does not directly follow the conditions of R3 or R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save strobe (interrupt taken) |
| pop_i | input | 1 | Restore strobe (return from interrupt) |
| ctx_i | input | CTX_W | Context word to save |
| restore_o | output | CTX_W | Word returned by the latest restore |
| top_o | output | CTX_W | Current top slot |
| bot_o | output | CTX_W | Current bottom slot |
| count_o | output | $clog2(DEPTH+1) | Number of valid saved levels |
| ovf_o | output | 1 | One-cycle pulse: a save discarded the oldest word |
| unf_o | output | 1 | One-cycle pulse: a restore found the stack empty |

## Verification
A save and a restore can be requested in the same cycle. The same cycle can also hit the stack's edge conditions: a save into a full stack, or a restore from an empty one. The bench runs every four-step sequence of idle, save, restore and simultaneous save-plus-restore from reset, so both strobes meet each level count from empty to full. After every edge it compares all outputs against an arithmetic model. That model applies the save and drops the restore when both strobes are high, so any leak of the restore into the slots, the restored word or the underflow flag shows up as a mismatch.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

   // Decoded operation for one clock cycle
   typedef enum logic [1:0] {
      STK_IDLE  = 2'd0,
      STK_PUSH  = 2'd1,
      STK_POP   = 2'd2,
      STK_UNDER = 2'd3
   } stk_op_e;

endpackage

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl
   import ctx_stack_pkg::*;
#(
   parameter int DEPTH = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   output stk_op_e          op_o,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o,
   output logic             unf_o
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             unf_q;
   stk_op_e          op;

   // Save wins over restore; an empty restore is its own operation
   always_comb begin
      if (push_i)
         op = STK_PUSH;
      else if (pop_i)
         op = (count_q == '0) ? STK_UNDER : STK_POP;
      else
         op = STK_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         ovf_q <= (op == STK_PUSH) && (count_q == FULL);
         unf_q <= (op == STK_UNDER);
         case (op)
            STK_PUSH: if (count_q != FULL) count_q <= count_q + 1'b1;
            STK_POP:  count_q <= count_q - 1'b1;
            default:  ;
         endcase
      end
   end

   assign op_o    = op;
   assign count_o = count_q;
   assign ovf_o   = ovf_q;
   assign unf_o   = unf_q;

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= FULL);
   assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && (count_o != FULL) |=> count_o == $past(count_o) + 1'b1);
   assert_ovf_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && (count_o == FULL) |=> ovf_o && (count_o == FULL));
   assert_unf_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && (count_o == '0) |=> unf_o && (count_o == '0));
   assert_both_no_unf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && pop_i |=> !unf_o);
   assert_flags_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !push_i && !pop_i |=> !ovf_o && !unf_o);

endmodule

// File: rtl/ctx_stack_slots.sv
module ctx_stack_slots
   import ctx_stack_pkg::*;
#(
   parameter int DEPTH          = 2,
   parameter int WIDTH          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   input  logic [WIDTH-1:0] ctx_i,
   output logic [WIDTH-1:0] top_o,
   output logic [WIDTH-1:0] bot_o,
   output logic [WIDTH-1:0] restore_o
);

   localparam int LAST = DEPTH - 1;

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [WIDTH-1:0] slot_d [DEPTH];
   logic [WIDTH-1:0] rest_q;
   logic [WIDTH-1:0] rest_d;
   logic             take;

   // Next value per slot: shift down on save, shift up on restore,
   // the last slot holds on restore
   for (genvar i = 0; i < DEPTH; i++) begin : g_next
      if (i == 0) begin : g_head
         always_comb begin
            case (op_i)
               STK_PUSH: slot_d[i] = ctx_i;
               STK_POP:  slot_d[i] = slot_q[i+1];
               default:  slot_d[i] = slot_q[i];
            endcase
         end
      end else if (i == LAST) begin : g_tail
         always_comb begin
            case (op_i)
               STK_PUSH: slot_d[i] = slot_q[i-1];
               default:  slot_d[i] = slot_q[i];
            endcase
         end
      end else begin : g_mid
         always_comb begin
            case (op_i)
               STK_PUSH: slot_d[i] = slot_q[i-1];
               STK_POP:  slot_d[i] = slot_q[i+1];
               default:  slot_d[i] = slot_q[i];
            endcase
         end
      end
   end

   assign take   = (op_i == STK_POP) || (op_i == STK_UNDER);
   assign rest_d = take ? slot_q[0] : rest_q;

   // Storage flops: reset variant chosen by parameter
   if (CLEAR_ON_RESET) begin : g_clr
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rest_q <= '0;
         else        rest_q <= rest_d;
      end
   end else begin : g_noclr
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) slot_q[i] <= slot_d[i];
      end
      always_ff @(posedge clk) rest_q <= rest_d;
   end

   assign top_o     = slot_q[0];
   assign bot_o     = slot_q[LAST];
   assign restore_o = rest_q;

   assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_PUSH |=> top_o == $past(ctx_i));
   assert_push_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_PUSH |=> bot_o == $past(slot_q[LAST-1]));
   assert_pop_keep_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_POP |=> $stable(bot_o));
   assert_pop_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_POP |=> top_o == $past(slot_q[1]));
   assert_restore_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> restore_o == $past(top_o));
   assert_under_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_UNDER |=> $stable(top_o) && $stable(bot_o));
   assert_push_keeps_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == STK_PUSH |=> $stable(restore_o));

endmodule

// File: rtl/ctx_shift_stack.sv
module ctx_shift_stack
   import ctx_stack_pkg::*;
#(
   parameter int CTX_W          = 8,
   parameter int DEPTH          = 2,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [CTX_W-1:0] ctx_i,
   output logic [CTX_W-1:0] restore_o,
   output logic [CTX_W-1:0] top_o,
   output logic [CTX_W-1:0] bot_o,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o,
   output logic             unf_o
);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("ctx_shift_stack: DEPTH must be at least 2");
   end
   if (CTX_W < 1) begin : g_bad_width
      $error("ctx_shift_stack: CTX_W must be at least 1");
   end

   stk_op_e op;

   ctx_stack_ctrl #(
      .DEPTH (DEPTH)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_i),
      .pop_i   (pop_i),
      .op_o    (op),
      .count_o (count_o),
      .ovf_o   (ovf_o),
      .unf_o   (unf_o)
   );

   ctx_stack_slots #(
      .DEPTH          (DEPTH),
      .WIDTH          (CTX_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) slots_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .ctx_i     (ctx_i),
      .top_o     (top_o),
      .bot_o     (bot_o),
      .restore_o (restore_o)
   );

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && unf_o));

endmodule

// File: tb/ctx_shift_stack_tb_top.sv
module ctx_shift_stack_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         push_i = 1'b0;
   logic         pop_i = 1'b0;
   logic [W-1:0] ctx_i = '0;
   logic [W-1:0] restore_o, top_o, bot_o;
   logic [1:0]   count_o;
   logic         ovf_o, unf_o;

   int n_chk = 0;
   int n_err = 0;

   // reference model
   logic [W-1:0] m_top, m_bot, m_rest;
   int           m_cnt;
   logic         m_ovf, m_unf;

   always #2 clk = ~clk;

   ctx_shift_stack #(.CTX_W(W), .DEPTH(2), .CLEAR_ON_RESET(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .ctx_i(ctx_i),
      .restore_o(restore_o), .top_o(top_o), .bot_o(bot_o), .count_o(count_o),
      .ovf_o(ovf_o), .unf_o(unf_o));

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "top", int'(top_o), int'(m_top));
      chk(req, "bottom", int'(bot_o), int'(m_bot));
      chk(req, "restore", int'(restore_o), int'(m_rest));
      chk(req, "count", int'(count_o), m_cnt);
      chk(req, "ovf", int'(ovf_o), int'(m_ovf));
      chk(req, "unf", int'(unf_o), int'(m_unf));
   endtask

   task automatic model_reset();
      m_top = '0; m_bot = '0; m_rest = '0; m_cnt = 0; m_ovf = 0; m_unf = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; push_i = 0; pop_i = 0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // op: 0 idle, 1 save, 2 restore, 3 both; drives at negedge, model updated
   task automatic step(input int op, input logic [W-1:0] d);
      push_i = op[0];
      pop_i  = op[1];
      ctx_i  = d;
      m_ovf = 0; m_unf = 0;
      if (op[0]) begin
         m_ovf = (m_cnt == 2);
         m_bot = m_top;
         m_top = d;
         if (m_cnt < 2) m_cnt++;
      end else if (op[1]) begin
         m_rest = m_top;
         if (m_cnt == 0) m_unf = 1;
         else begin
            m_top = m_bot;
            m_cnt--;
         end
      end
      @(negedge clk);
      push_i = 0; pop_i = 0;
   endtask

   function automatic string req_of(input int op, input int cnt_before);
      case (op)
         1: return (cnt_before == 2) ? "R3" : "R2";
         2: return (cnt_before == 0) ? "R6" : "R4";
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      model_reset();
      do_reset();
      chk_all("R1");

      // R5: directed nesting sequence A, B, C, restore, restore
      step(1, 8'hA1); chk("R5", "top A", int'(top_o), 8'hA1); chk("R5", "bot A", int'(bot_o), 0);
      step(1, 8'hB2); chk("R5", "top B", int'(top_o), 8'hB2); chk("R5", "bot B", int'(bot_o), 8'hA1);
      step(1, 8'hC3); chk("R5", "top C", int'(top_o), 8'hC3); chk("R5", "bot C", int'(bot_o), 8'hB2);
      chk("R5", "ovf C", int'(ovf_o), 1);
      step(2, 8'h00); chk("R5", "rest1", int'(restore_o), 8'hC3);
      chk("R5", "top r1", int'(top_o), 8'hB2); chk("R5", "bot r1", int'(bot_o), 8'hB2);
      step(2, 8'h00); chk("R5", "rest2", int'(restore_o), 8'hB2);
      chk("R5", "top r2", int'(top_o), 8'hB2); chk("R5", "bot r2", int'(bot_o), 8'hB2);
      chk("R5", "count", int'(count_o), 0);

      // Exhaustive sweep: every 4-step sequence of the four operations
      for (int s = 0; s < 256; s++) begin
         do_reset();
         chk_all("R1");
         for (int k = 0; k < 4; k++) begin
            int op;
            int cb;
            op = (s >> (2 * k)) & 3;
            cb = m_cnt;
            step(op, W'((s << 2) | k) ^ 8'h5A);
            chk_all(req_of(op, cb));
         end
         step(0, 8'h00);
         chk_all("R8");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule